// File: doc/BRIEF.md
# Parallel NOR Flash Program and Erase Sequencer

This block sits on the host side of an asynchronous 16-bit parallel NOR flash. It takes one request at a time and turns it into the flash's command protocol. A request carries an operation code, a word address, a data word, a sector bitmask and a start pulse. The supported operations are word program, chip erase and multi-sector erase. The block drives chip select, write enable, output enable, the address bus and the data bus. Each strobe phase lasts a whole number of clock cycles, and those counts are derived from `CLK_PERIOD_NS` by rounding up the flash's minimum times.

After the last command write, the block reads the target location repeatedly. The embedded algorithm is finished once bit 7 of each byte lane matches the expected value. The expected value is the programmed word for a program and all ones for an erase. A timeout bounds the polling: the limit scales with the worst-case program, sector erase or chip erase duration. The block reports success or failure with a single-cycle pulse on `done` or `err`.

Top module: `flash_pe_ctrl`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `fl_dq_oe` are 0, and `fl_ce_n`, `fl_we_n` and `fl_oe_n` are 1.
- R2: Operation code 0 (program) issues exactly four writes, in this order: 16'hAAAA to 19'h05555, 16'h5555 to 19'h02AAA, 16'hA0A0 to 19'h05555, then `wdata` to `addr`.
- R3: Operation code 2 (chip erase) issues exactly six writes: 16'hAAAA to 19'h05555, 16'h5555 to 19'h02AAA, 16'h8080 to 19'h05555, 16'hAAAA to 19'h05555, 16'h5555 to 19'h02AAA, then 16'h1010 to 19'h05555.
- R4: Operation code 1 (sector erase) issues the first five writes of R3. It then writes 16'h3030 once to each sector whose mask bit is set, in ascending sector index order. The base of sector i is i shifted left by 16 (word address).
- R5: After the writes, the block reads the poll address until bits 7 and 15 of the read data equal those of the expected word. It then pulses `done` for one cycle and drops `busy`. The poll address is `addr` for a program, the lowest selected sector base for a sector erase, and 0 for a chip erase. The expected word is `wdata` for a program and 16'hFFFF for an erase. `done` never rises before the device reports completion.
- R6: Polling runs for a limit counted from its start. The limit is ceil(T_us*1000/CLK_PERIOD_NS) cycles, where T_us is the program, sector erase or chip erase maximum for the operation. If a poll read fails and the limit has been reached, the block pulses `err` for one cycle, never `done`, with all strobes high, and returns to idle.
- R7: A `start` pulse while `busy` is 1 is ignored. The running operation's write sequence is unchanged.
- R8: In each write, `fl_we_n` is low for at least ceil(45/T) cycles while `fl_ce_n` is low and the address is stable. It is high for at least ceil(20/T) cycles between writes, and consecutive falling edges are at least ceil(90/T) cycles apart.
- R9: `fl_oe_n` is never low while `fl_we_n` is low or `fl_dq_oe` is 1. Each poll read holds `fl_oe_n` low for at least ceil(35/T) cycles.
- R10: A sector erase with an all-zero mask pulses `err` for one cycle and causes no bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, sampled when idle |
| op | input | 2 | 0 program, 1 sector erase, 2 chip erase |
| addr | input | ADDR_W | Word address for program |
| wdata | input | DATA_W | Word to program |
| sect_mask | input | N_SECT | Sectors to erase (sector erase) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle failure pulse (timeout or empty mask) |
| fl_ce_n | output | 1 | Flash chip select, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_addr | output | ADDR_W | Flash word address |
| fl_dq_out | output | DATA_W | Data driven to flash |
| fl_dq_oe | output | 1 | Host drives the data bus when 1 |
| fl_dq_in | input | DATA_W | Data read from flash |

## Verification
The assertions assume that the flash returns its read data on `fl_dq_in` during the cycles that `fl_oe_n` is low. They also assume that `start` is a clean synchronous pulse whose `op`, `addr`, `wdata` and `sect_mask` are valid in the same cycle. The bench meets these assumptions in two ways. Its behavioural flash drives read data combinationally from `fl_oe_n`, showing inverted bit 7 and bit 15 until a chosen completion cycle. Request fields are set up one half-cycle before `start` rises and held for the whole operation.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  typedef enum logic [1:0] {
    OPC_PROG  = 2'd0,
    OPC_SECT  = 2'd1,
    OPC_CHIP  = 2'd2
  } opc_t;

  function automatic int unsigned ceil_div(input longint unsigned n, input longint unsigned d);
    return int'((n + d - 1) / d);
  endfunction
endpackage

// File: rtl/fpc_bus.sv
module fpc_bus #(
  parameter int CLK_PERIOD_NS = 20,
  parameter int ADDR_W        = 19,
  parameter int DATA_W        = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              wr,
  input  logic [ADDR_W-1:0] a_in,
  input  logic [DATA_W-1:0] d_in,
  output logic              ack,
  output logic [DATA_W-1:0] rdata,
  output logic              ce_n,
  output logic              we_n,
  output logic              oe_n,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  input  logic [DATA_W-1:0] dq_in
);
  import fpc_pkg::*;

  localparam int WP_CYC  = ceil_div(45, CLK_PERIOD_NS);
  localparam int WPH_CYC = ceil_div(20, CLK_PERIOD_NS);
  localparam int WC_CYC  = ceil_div(90, CLK_PERIOD_NS);
  localparam int WHI_CYC = (WC_CYC - WP_CYC > WPH_CYC) ? WC_CYC - WP_CYC : WPH_CYC;
  localparam int OE_CYC  = ceil_div(35, CLK_PERIOD_NS);
  localparam int OEH_RAW = ceil_div(10, CLK_PERIOD_NS);
  localparam int OEH_CYC = (OEH_RAW < 1) ? 1 : OEH_RAW;
  localparam int MAX_CYC = (WP_CYC > WHI_CYC) ? ((WP_CYC > OE_CYC) ? WP_CYC : OE_CYC)
                                              : ((WHI_CYC > OE_CYC) ? WHI_CYC : OE_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC + 1) + 1;

  typedef enum logic [1:0] {B_IDLE, B_SETUP, B_LOW, B_HIGH} bst_t;
  bst_t st;
  logic [CNT_W-1:0] cnt;
  logic             wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= B_IDLE; cnt <= '0; wr_q <= 1'b0; ack <= 1'b0;
      rdata <= '0; ce_n <= 1'b1; we_n <= 1'b1; oe_n <= 1'b1;
      addr <= '0; dq_out <= '0; dq_oe <= 1'b0;
    end else begin
      ack <= 1'b0;
      case (st)
        B_IDLE: if (go) begin
          wr_q   <= wr;
          addr   <= a_in;
          dq_out <= d_in;
          dq_oe  <= wr;
          ce_n   <= 1'b0;
          st     <= B_SETUP;
        end
        B_SETUP: begin
          if (wr_q) begin
            we_n <= 1'b0;
            cnt  <= CNT_W'(WP_CYC - 1);
          end else begin
            oe_n <= 1'b0;
            cnt  <= CNT_W'(OE_CYC - 1);
          end
          st <= B_LOW;
        end
        B_LOW: begin
          if (cnt == '0) begin
            we_n  <= 1'b1;
            oe_n  <= 1'b1;
            ce_n  <= 1'b1;
            dq_oe <= 1'b0;
            if (!wr_q) rdata <= dq_in;
            cnt   <= wr_q ? CNT_W'(WHI_CYC - 1) : CNT_W'(OEH_CYC - 1);
            st    <= B_HIGH;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (cnt == '0) begin
            ack <= 1'b1;
            st  <= B_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      endcase
    end
  end

  // Checker-side run length of the write and read strobes
  logic [CNT_W-1:0] we_run, oe_run;
  always_ff @(posedge clk) begin
    if (rst) begin
      we_run <= '0; oe_run <= '0;
    end else begin
      we_run <= we_n ? '0 : we_run + 1'b1;
      oe_run <= oe_n ? '0 : oe_run + 1'b1;
    end
  end

  AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (rst) !we_n |-> !ce_n); // R8
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    (!we_n && $past(!we_n)) |-> ($stable(addr) && $stable(dq_out))); // R8
  AST_WE_MIN_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(we_n) |-> (32'(we_run) >= 32'(WP_CYC))); // R8
  AST_OE_EXCL: assert property (@(posedge clk) disable iff (rst) !oe_n |-> (we_n && !dq_oe)); // R9
  AST_OE_MIN_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(oe_n) |-> (32'(oe_run) >= 32'(OE_CYC))); // R9
endmodule

// File: rtl/fpc_cmd_gen.sv
module fpc_cmd_gen #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16,
  parameter int SECT_W = 3
) (
  input  fpc_pkg::opc_t     op,
  input  logic [2:0]        step,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic [DATA_W-1:0] tgt_data,
  input  logic [SECT_W-1:0] sect_idx,
  output logic [ADDR_W-1:0] c_addr,
  output logic [DATA_W-1:0] c_data,
  output logic              c_last
);
  import fpc_pkg::*;

  localparam int LANES = DATA_W / 8;
  localparam logic [ADDR_W-1:0] UNLK_A = ADDR_W'(20'h05555);
  localparam logic [ADDR_W-1:0] UNLK_B = ADDR_W'(20'h02AAA);

  function automatic logic [DATA_W-1:0] rep(input logic [7:0] b);
    return {LANES{b}};
  endfunction

  logic [ADDR_W-1:0] sect_base;
  assign sect_base = {sect_idx, {(ADDR_W-SECT_W){1'b0}}};

  always_comb begin
    c_addr = UNLK_A;
    c_data = rep(8'hAA);
    c_last = (op == OPC_PROG) ? (step == 3'd3) : (step == 3'd5);
    case (step)
      3'd0: begin c_addr = UNLK_A; c_data = rep(8'hAA); end
      3'd1: begin c_addr = UNLK_B; c_data = rep(8'h55); end
      3'd2: begin c_addr = UNLK_A; c_data = (op == OPC_PROG) ? rep(8'hA0) : rep(8'h80); end
      3'd3: begin
        c_addr = (op == OPC_PROG) ? tgt_addr : UNLK_A;
        c_data = (op == OPC_PROG) ? tgt_data : rep(8'hAA);
      end
      3'd4: begin c_addr = UNLK_B; c_data = rep(8'h55); end
      default: begin
        c_addr = (op == OPC_CHIP) ? UNLK_A : sect_base;
        c_data = (op == OPC_CHIP) ? rep(8'h10) : rep(8'h30);
      end
    endcase
  end
endmodule

// File: rtl/flash_pe_ctrl.sv
module flash_pe_ctrl #(
  parameter int CLK_PERIOD_NS = 20,
  parameter int ADDR_W        = 19,
  parameter int DATA_W        = 16,
  parameter int N_SECT        = 8,
  parameter int PROG_MAX_US   = 300,
  parameter int SECT_MAX_US   = 15000000,
  parameter int CHIP_MAX_US   = 64000000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [N_SECT-1:0] sect_mask,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              fl_ce_n,
  output logic              fl_we_n,
  output logic              fl_oe_n,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [DATA_W-1:0] fl_dq_out,
  output logic              fl_dq_oe,
  input  logic [DATA_W-1:0] fl_dq_in
);
  import fpc_pkg::*;

  localparam int SECT_W = $clog2(N_SECT);
  localparam longint unsigned PROG_LIM = (longint'(PROG_MAX_US) * 1000 + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam longint unsigned SECT_LIM = (longint'(SECT_MAX_US) * 1000 + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam longint unsigned CHIP_LIM = (longint'(CHIP_MAX_US) * 1000 + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam longint unsigned MAX_LIM  = (PROG_LIM > SECT_LIM) ? ((PROG_LIM > CHIP_LIM) ? PROG_LIM : CHIP_LIM)
                                                             : ((SECT_LIM > CHIP_LIM) ? SECT_LIM : CHIP_LIM);
  localparam int TMO_W = $clog2(MAX_LIM + 1) + 1;
  localparam logic [DATA_W-1:0] POLL_MASK = {(DATA_W/8){8'h80}};

  typedef enum logic [2:0] {T_IDLE, T_CMD, T_CMDW, T_POLL, T_POLLW} tst_t;
  tst_t st;

  opc_t              op_q;
  logic [ADDR_W-1:0] addr_q, poll_addr;
  logic [DATA_W-1:0] data_q, exp_q;
  logic [N_SECT-1:0] mask_q;
  logic [2:0]        step;
  logic [TMO_W-1:0]  tcnt, lim;

  function automatic logic [SECT_W-1:0] lowest(input logic [N_SECT-1:0] m);
    logic [SECT_W-1:0] r;
    r = '0;
    for (int i = N_SECT - 1; i >= 0; i--) if (m[i]) r = SECT_W'(i);
    return r;
  endfunction

  logic [ADDR_W-1:0] c_addr;
  logic [DATA_W-1:0] c_data, rdata;
  logic              c_last, ack, bus_go, bus_wr;
  logic [N_SECT-1:0] mask_next;
  assign mask_next = mask_q & (mask_q - 1'b1);

  fpc_cmd_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W)) u_cmd (
    .op(op_q), .step(step), .tgt_addr(addr_q), .tgt_data(data_q),
    .sect_idx(lowest(mask_q)), .c_addr(c_addr), .c_data(c_data), .c_last(c_last)
  );

  assign bus_go = (st == T_CMD) || (st == T_POLL);
  assign bus_wr = (st == T_CMD);

  fpc_bus #(.CLK_PERIOD_NS(CLK_PERIOD_NS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk(clk), .rst(rst), .go(bus_go), .wr(bus_wr),
    .a_in(bus_wr ? c_addr : poll_addr), .d_in(c_data),
    .ack(ack), .rdata(rdata), .ce_n(fl_ce_n), .we_n(fl_we_n), .oe_n(fl_oe_n),
    .addr(fl_addr), .dq_out(fl_dq_out), .dq_oe(fl_dq_oe), .dq_in(fl_dq_in)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= T_IDLE; op_q <= OPC_PROG; addr_q <= '0; data_q <= '0; mask_q <= '0;
      poll_addr <= '0; exp_q <= '0; step <= '0; tcnt <= '0; lim <= '0;
      busy <= 1'b0; done <= 1'b0; err <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (st)
        T_IDLE: if (start) begin
          op_q   <= opc_t'(op);
          addr_q <= addr;
          data_q <= wdata;
          mask_q <= sect_mask;
          step   <= '0;
          tcnt   <= '0;
          case (opc_t'(op))
            OPC_PROG: begin poll_addr <= addr; exp_q <= wdata; lim <= TMO_W'(PROG_LIM); end
            OPC_SECT: begin
              poll_addr <= {lowest(sect_mask), {(ADDR_W-SECT_W){1'b0}}};
              exp_q <= '1; lim <= TMO_W'(SECT_LIM);
            end
            default: begin poll_addr <= '0; exp_q <= '1; lim <= TMO_W'(CHIP_LIM); end
          endcase
          if (opc_t'(op) == OPC_SECT && sect_mask == '0) begin
            err <= 1'b1;
          end else begin
            busy <= 1'b1;
            st   <= T_CMD;
          end
        end
        T_CMD: st <= T_CMDW;
        T_CMDW: if (ack) begin
          if (!c_last) begin
            step <= step + 1'b1;
            st   <= T_CMD;
          end else if (op_q == OPC_SECT && mask_next != '0) begin
            mask_q <= mask_next;
            st     <= T_CMD;
          end else begin
            st <= T_POLL;
          end
        end
        T_POLL: begin
          tcnt <= tcnt + 1'b1;
          st   <= T_POLLW;
        end
        default: begin
          tcnt <= tcnt + 1'b1;
          if (ack) begin
            if (((rdata ^ exp_q) & POLL_MASK) == '0) begin
              done <= 1'b1; busy <= 1'b0; st <= T_IDLE;
            end else if (tcnt >= lim) begin
              err <= 1'b1; busy <= 1'b0; st <= T_IDLE;
            end else begin
              st <= T_POLL;
            end
          end
        end
      endcase
    end
  end

  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (rst) !(done && err)); // R5
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst) done |-> !busy); // R5
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
    err |-> (fl_ce_n && fl_we_n && fl_oe_n && !fl_dq_oe)); // R6
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && busy) |-> ($stable(op_q) && $stable(addr_q) && $stable(data_q))); // R7
  AST_EMPTY_MASK: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && op == 2'd1 && sect_mask == '0) |=> (err && !busy)); // R10
endmodule

// File: tb/tb_flash_pe_ctrl.sv
module tb_flash_pe_ctrl;
  localparam int T = 20;
  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [1:0]  op = 2'd0;
  logic [18:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [7:0]  sect_mask = '0;
  logic busy, done, err, fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe;
  logic [18:0] fl_addr;
  logic [15:0] fl_dq_out, fl_dq_in;

  always #(T/2) clk = ~clk;

  flash_pe_ctrl #(.CLK_PERIOD_NS(T), .PROG_MAX_US(2), .SECT_MAX_US(20), .CHIP_MAX_US(40)) dut (
    .clk(clk), .rst(rst), .start(start), .op(op), .addr(addr), .wdata(wdata),
    .sect_mask(sect_mask), .busy(busy), .done(done), .err(err),
    .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n), .fl_addr(fl_addr),
    .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in)
  );

  int tests = 0, fails = 0;
  int cyc = 0;
  int ready_cyc = 0;
  logic [15:0] stub_val = '0;

  // Behavioural flash: inverted bit 7/15 until ready
  assign fl_dq_in = fl_oe_n ? 16'h0000 : ((cyc < ready_cyc) ? (stub_val ^ 16'h8080) : stub_val);

  always @(posedge clk) cyc <= cyc + 1;

  // Bus monitor
  int wcnt = 0;
  logic [18:0] wa [0:31];
  logic [15:0] wd [0:31];
  logic prev_we = 1'b1, prev_oe = 1'b1;
  int lo = 0, hi = 0, per = 0, oelo = 0;
  int min_lo = 999, min_hi = 999, min_per = 999, min_oe = 999, nfall = 0, noe = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (!fl_we_n) lo++; else hi++;
      per++;
      if (prev_we && !fl_we_n) begin
        if (nfall > 0) begin
          if (hi < min_hi) min_hi = hi;
          if (per < min_per) min_per = per;
        end
        nfall++; per = 0; lo = 1;
      end
      if (!prev_we && fl_we_n) begin
        if (lo < min_lo) min_lo = lo;
        if (wcnt < 32) begin wa[wcnt] = fl_addr; wd[wcnt] = fl_dq_out; end
        wcnt++; hi = 1;
      end
      if (!fl_oe_n) oelo++;
      if (!prev_oe && fl_oe_n) begin
        if (oelo < min_oe) min_oe = oelo;
        noe++;
      end
      if (prev_oe && !fl_oe_n) oelo = 1;
      prev_we = fl_we_n;
      prev_oe = fl_oe_n;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clr_mon();
    wcnt = 0; nfall = 0; noe = 0;
    min_lo = 999; min_hi = 999; min_per = 999; min_oe = 999;
  endtask

  task automatic kick(input logic [1:0] o, input logic [18:0] a, input logic [15:0] d, input logic [7:0] m);
    @(negedge clk);
    op = o; addr = a; wdata = d; sect_mask = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Waits for done or err; returns code 1=done 2=err 0=none and cycle seen
  task automatic wait_end(input int maxc, output int code, output int at);
    code = 0; at = 0;
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      if (done || err) begin
        code = done ? 1 : 2; at = cyc;
        if (done && err) code = 3;
        break;
      end
    end
  endtask

  task automatic chk_write(input int idx, input logic [18:0] ea, input logic [15:0] ed, input string tag);
    chk(wa[idx] == ea, tag, int'(wa[idx]), int'(ea));
    chk(wd[idx] == ed, tag, int'(wd[idx]), int'(ed));
  endtask

  task automatic t_reset();
    chk(!busy && !done && !err && !fl_dq_oe, "R1 flags", {busy, done, err, fl_dq_oe}, 0);
    chk(fl_ce_n && fl_we_n && fl_oe_n, "R1 strobes", {fl_ce_n, fl_we_n, fl_oe_n}, 7);
  endtask

  task automatic t_program();
    int code, at, t0;
    clr_mon();
    stub_val = 16'h1234;
    t0 = cyc;
    ready_cyc = cyc + 80;
    kick(2'd0, 19'h4_1357, 16'h1234, 8'h00);
    chk(busy, "R2 busy after start", busy, 1);
    wait_end(2000, code, at);
    chk(code == 1, "R5 program done", code, 1);
    chk(at >= ready_cyc, "R5 done not early", at, ready_cyc);
    chk(wcnt == 4, "R2 write count", wcnt, 4);
    chk_write(0, 19'h05555, 16'hAAAA, "R2 w0");
    chk_write(1, 19'h02AAA, 16'h5555, "R2 w1");
    chk_write(2, 19'h05555, 16'hA0A0, "R2 w2");
    chk_write(3, 19'h4_1357, 16'h1234, "R2 w3");
    chk(min_lo >= 3, "R8 we low width", min_lo, 3);
    chk(min_hi >= 1, "R8 we high width", min_hi, 1);
    chk(min_per >= 5, "R8 write period", min_per, 5);
    chk(noe >= 1 && min_oe >= 2, "R9 oe low width", min_oe, 2);
    @(negedge clk);
    chk(!busy && !done, "R5 done single cycle", {busy, done}, 0);
    if (t0 < 0) $display("unused");
  endtask

  task automatic t_chip();
    int code, at;
    clr_mon();
    stub_val = 16'hFFFF;
    ready_cyc = cyc + 300;
    kick(2'd2, 19'h0, 16'h0, 8'h00);
    wait_end(5000, code, at);
    chk(code == 1, "R3 chip erase done", code, 1);
    chk(at >= ready_cyc, "R5 chip done not early", at, ready_cyc);
    chk(wcnt == 6, "R3 write count", wcnt, 6);
    chk_write(2, 19'h05555, 16'h8080, "R3 w2");
    chk_write(3, 19'h05555, 16'hAAAA, "R3 w3");
    chk_write(4, 19'h02AAA, 16'h5555, "R3 w4");
    chk_write(5, 19'h05555, 16'h1010, "R3 w5");
  endtask

  task automatic t_sector();
    int code, at;
    clr_mon();
    stub_val = 16'hFFFF;
    ready_cyc = cyc + 400;
    kick(2'd1, 19'h0, 16'h0, 8'b1010_0100);
    wait_end(5000, code, at);
    chk(code == 1, "R4 sector erase done", code, 1);
    chk(wcnt == 8, "R4 write count", wcnt, 8);
    chk_write(2, 19'h05555, 16'h8080, "R4 w2");
    chk_write(5, 19'h2_0000, 16'h3030, "R4 sector 2");
    chk_write(6, 19'h5_0000, 16'h3030, "R4 sector 5");
    chk_write(7, 19'h7_0000, 16'h3030, "R4 sector 7");
  endtask

  task automatic t_timeout();
    int code, at, t0;
    clr_mon();
    stub_val = 16'h00FF;
    ready_cyc = 32'h7fff_ffff;
    t0 = cyc;
    kick(2'd0, 19'h00010, 16'h00FF, 8'h00);
    wait_end(3000, code, at);
    chk(code == 2, "R6 timeout err", code, 2);
    chk(at - t0 >= 100, "R6 not before limit", at - t0, 100);
    chk(fl_ce_n && fl_we_n && fl_oe_n, "R6 strobes idle", {fl_ce_n, fl_we_n, fl_oe_n}, 7);
    @(negedge clk);
    chk(!busy && !err, "R6 back to idle", {busy, err}, 0);
  endtask

  task automatic t_busy_start();
    int code, at;
    clr_mon();
    stub_val = 16'h5A5A;
    ready_cyc = cyc + 80;
    kick(2'd0, 19'h00222, 16'h5A5A, 8'h00);
    repeat (5) @(negedge clk);
    kick(2'd2, 19'h0, 16'h0, 8'h00);
    wait_end(2000, code, at);
    chk(code == 1, "R7 first op completes", code, 1);
    chk(wcnt == 4, "R7 start ignored", wcnt, 4);
    chk_write(3, 19'h00222, 16'h5A5A, "R7 target kept");
    repeat (20) @(negedge clk);
    chk(!busy && wcnt == 4, "R7 no late op", wcnt, 4);
  endtask

  task automatic t_empty_mask();
    int code, at;
    clr_mon();
    kick(2'd1, 19'h0, 16'h0, 8'h00);
    chk(err && !busy, "R10 empty mask err", {err, busy}, 2);
    wait_end(40, code, at);
    chk(wcnt == 0 && noe == 0, "R10 no bus activity", wcnt + noe, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_program();
    t_chip();
    t_sector();
    t_timeout();
    t_busy_start();
    t_empty_mask();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule